// File: doc/BRIEF.md
# Framed Message Receive Address Filter

This block sits between a terminal's serial character receiver and its display memory and decides which received characters are allowed through. A message counts only when it opens with a start-of-text character and the character right after it names this terminal, either through the terminal's own device address or through the shared broadcast address. Every terminal on the line reacts to start-of-text, and each one then keeps or drops the message depending on the address character that follows.

Two flags track the framing: one records that start-of-text has been seen, and the other records that the address matched. When both are set, the receive-enable output is high, and each later character is passed to the gated output with a one-cycle valid strobe. End-of-text is passed as the last character and closes the message. Reception is blocked entirely while the terminal transmits, and a transmit that starts in the middle of a message cancels that message.

Top module: `msg_rx_filter`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` and `rx_enable` are 0.
- R2: A character is taken into the front register at a clock edge only when `rx_valid` is 1 and `tx_busy` is 0 at that edge. Characters offered while `tx_busy` is 1 have no effect on `out_valid` or `rx_enable`.
- R3: A front-register character equal to STX (0x02) sets the start flag and clears the address flag at the next edge, whatever the current state. This includes a restart in the middle of an enabled message, where `rx_enable` falls.
- R4: When the start flag is set and the address flag is clear, a character equal to {1'b0, `dev_addr`} sets the address flag, and `rx_enable` rises at the next edge.
- R5: In the same position, a character equal to {1'b0, `bcast_addr`} also sets the address flag.
- R6: In the same position, a character that is neither accepted address nor STX clears both flags at the next edge. No later character is forwarded until a new STX arrives.
- R7: `rx_enable` is 1 exactly when both flags are set. While it is 1, each character accepted at edge k appears on `out_char` with `out_valid` high for the single cycle after edge k+1.
- R8: An ETX (0x03) accepted while `rx_enable` is 1 is forwarded as the last character. Both flags clear at the same edge at which it appears on the output.
- R9: `tx_busy` high at an edge clears both flags and drops any character held in the front register.
- R10: STX and address characters are never forwarded, and characters that arrive outside an enabled message are never forwarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_char | input | CHAR_W | Received character |
| rx_valid | input | 1 | Qualifies `rx_char` for one cycle |
| dev_addr | input | ADDR_W | This terminal's programmed address |
| bcast_addr | input | ADDR_W | Address that every terminal accepts |
| tx_busy | input | 1 | High while the terminal transmits |
| out_char | output | CHAR_W | Forwarded character |
| out_valid | output | 1 | One-cycle strobe for `out_char` |
| rx_enable | output | 1 | High while a message addressed to this terminal is open |

## Verification
The filter is exercised with a message to the device address and with a message to the broadcast address; the match to either address forwards the same payload. A wrong address and stray characters on an idle line show that the mismatch reset works and that nothing leaks outside a message. A double STX, a restart in the middle of a message, and a `tx_busy` pulse both inside and outside a message separate the flag-clearing causes from one another. Idle gaps between characters show that the flags hold their state between strobes.

// File: rtl/msg_rx_pkg.sv
package msg_rx_pkg;
  typedef struct packed {
    logic start_seen;
    logic addr_ok;
  } frame_flags_t;

  localparam frame_flags_t FLAGS_IDLE = '{start_seen: 1'b0, addr_ok: 1'b0};
  localparam frame_flags_t FLAGS_WAIT = '{start_seen: 1'b1, addr_ok: 1'b0};
  localparam frame_flags_t FLAGS_OPEN = '{start_seen: 1'b1, addr_ok: 1'b1};
endpackage

// File: rtl/rx_front_reg.sv
module rx_front_reg #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAR_W-1:0] in_char,
  input  logic              in_valid,
  input  logic              tx_busy,
  output logic [CHAR_W-1:0] q_char,
  output logic              q_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_char  <= '0;
      q_valid <= 1'b0;
    end else begin
      q_valid <= in_valid & ~tx_busy;
      if (in_valid && !tx_busy)
        q_char <= in_char;
    end
  end

  assert_front_blocked_R2: assert property (@(posedge clk) disable iff (rst)
    tx_busy |=> !q_valid);
endmodule

// File: rtl/rx_addr_match.sv
module rx_addr_match #(
  parameter int CHAR_W   = 8,
  parameter int ADDR_W   = 7,
  parameter bit BCAST_EN = 1'b1
) (
  input  logic [CHAR_W-1:0] ch,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [ADDR_W-1:0] bcast_addr,
  output logic              hit
);
  localparam int PAD_W = CHAR_W - ADDR_W;

  logic [CHAR_W-1:0] dev_ch;
  logic [CHAR_W-1:0] bc_ch;
  logic              dev_hit;

  assign dev_ch  = {{PAD_W{1'b0}}, dev_addr};
  assign bc_ch   = {{PAD_W{1'b0}}, bcast_addr};
  assign dev_hit = (ch == dev_ch);

  generate
    if (BCAST_EN) begin : g_bcast
      assign hit = dev_hit | (ch == bc_ch);
    end else begin : g_nobcast
      logic unused_bc;
      assign unused_bc = ^bc_ch;
      assign hit = dev_hit;
    end
  endgenerate
endmodule

// File: rtl/rx_frame_ctl.sv
module rx_frame_ctl
  import msg_rx_pkg::*;
#(
  parameter int                CHAR_W   = 8,
  parameter logic [CHAR_W-1:0] STX_CODE = 8'h02,
  parameter logic [CHAR_W-1:0] ETX_CODE = 8'h03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_busy,
  input  logic              ch_valid,
  input  logic [CHAR_W-1:0] ch,
  input  logic              addr_hit,
  output logic              rx_enable,
  output logic              fwd
);
  frame_flags_t flags, flags_nxt;
  logic is_stx, is_etx;

  assign is_stx = (ch == STX_CODE);
  assign is_etx = (ch == ETX_CODE);

  always_comb begin
    flags_nxt = flags;
    fwd       = 1'b0;
    if (tx_busy) begin
      flags_nxt = FLAGS_IDLE;
    end else if (ch_valid) begin
      if (is_stx) begin
        flags_nxt = FLAGS_WAIT;
      end else if (flags == FLAGS_WAIT) begin
        flags_nxt = addr_hit ? FLAGS_OPEN : FLAGS_IDLE;
      end else if (flags == FLAGS_OPEN) begin
        fwd = 1'b1;
        if (is_etx)
          flags_nxt = FLAGS_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= FLAGS_IDLE;
    else     flags <= flags_nxt;
  end

  assign rx_enable = flags.start_seen & flags.addr_ok;

  assert_stx_restarts_R3: assert property (@(posedge clk) disable iff (rst)
    (ch_valid && !tx_busy && is_stx) |=> (flags.start_seen && !flags.addr_ok));
  assert_addr_opens_R4: assert property (@(posedge clk) disable iff (rst)
    (ch_valid && !tx_busy && !is_stx && flags == FLAGS_WAIT && addr_hit) |=> rx_enable);
  assert_mismatch_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (ch_valid && !tx_busy && !is_stx && flags == FLAGS_WAIT && !addr_hit)
      |=> (!flags.start_seen && !flags.addr_ok));
  assert_etx_closes_R8: assert property (@(posedge clk) disable iff (rst)
    (ch_valid && !tx_busy && rx_enable && is_etx) |=> (!flags.start_seen && !flags.addr_ok));
  assert_busy_clears_R9: assert property (@(posedge clk) disable iff (rst)
    tx_busy |=> (!flags.start_seen && !flags.addr_ok));
  assert_no_addr_without_start_R7: assert property (@(posedge clk) disable iff (rst)
    flags.addr_ok |-> flags.start_seen);
endmodule

// File: rtl/rx_out_stage.sv
module rx_out_stage #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fwd,
  input  logic [CHAR_W-1:0] ch,
  output logic [CHAR_W-1:0] out_char,
  output logic              out_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_char  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= fwd;
      if (fwd)
        out_char <= ch;
    end
  end
endmodule

// File: rtl/msg_rx_filter.sv
module msg_rx_filter #(
  parameter int                CHAR_W   = 8,
  parameter int                ADDR_W   = 7,
  parameter bit                BCAST_EN = 1'b1,
  parameter logic [CHAR_W-1:0] STX_CODE = 8'h02,
  parameter logic [CHAR_W-1:0] ETX_CODE = 8'h03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              rx_valid,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [ADDR_W-1:0] bcast_addr,
  input  logic              tx_busy,
  output logic [CHAR_W-1:0] out_char,
  output logic              out_valid,
  output logic              rx_enable
);
  logic [CHAR_W-1:0] d1_char;
  logic              d1_valid;
  logic              addr_hit;
  logic              fwd;

  rx_front_reg #(.CHAR_W(CHAR_W)) u_front (
    .clk(clk), .rst(rst), .in_char(rx_char), .in_valid(rx_valid),
    .tx_busy(tx_busy), .q_char(d1_char), .q_valid(d1_valid)
  );

  rx_addr_match #(.CHAR_W(CHAR_W), .ADDR_W(ADDR_W), .BCAST_EN(BCAST_EN)) u_match (
    .ch(d1_char), .dev_addr(dev_addr), .bcast_addr(bcast_addr), .hit(addr_hit)
  );

  rx_frame_ctl #(.CHAR_W(CHAR_W), .STX_CODE(STX_CODE), .ETX_CODE(ETX_CODE)) u_ctl (
    .clk(clk), .rst(rst), .tx_busy(tx_busy), .ch_valid(d1_valid), .ch(d1_char),
    .addr_hit(addr_hit), .rx_enable(rx_enable), .fwd(fwd)
  );

  rx_out_stage #(.CHAR_W(CHAR_W)) u_out (
    .clk(clk), .rst(rst), .fwd(fwd), .ch(d1_char),
    .out_char(out_char), .out_valid(out_valid)
  );

  assert_fwd_only_open_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(rx_enable));
  assert_no_stx_out_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_char != STX_CODE));
endmodule

// File: tb/msg_rx_filter_test.sv
module msg_rx_filter_test;
  localparam logic [7:0] STX = 8'h02;
  localparam logic [7:0] ETX = 8'h03;
  localparam logic [6:0] DEV = 7'h15;
  localparam logic [6:0] BC  = 7'h7F;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] rx_char = '0;
  logic       rx_valid = 1'b0;
  logic       tx_busy = 1'b0;
  logic [7:0] out_char;
  logic       out_valid, rx_enable;

  int checks = 0, failures = 0, cycles = 0, fwd_count = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  msg_rx_filter uut (
    .clk(clk), .rst(rst), .rx_char(rx_char), .rx_valid(rx_valid),
    .dev_addr(DEV), .bcast_addr(BC), .tx_busy(tx_busy),
    .out_char(out_char), .out_valid(out_valid), .rx_enable(rx_enable)
  );

  // behavioural reference: front slot, two flags, output slot
  bit         m_hv, m_st, m_ad, m_ov;
  logic [7:0] m_h, m_oc;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_hv = 0; m_st = 0; m_ad = 0; m_ov = 0; m_oc = 0; m_h = 0;
    end else begin
      m_ov = 0;
      if (tx_busy) begin
        m_st = 0; m_ad = 0;
      end else if (m_hv) begin
        if (m_h == STX) begin
          m_st = 1; m_ad = 0;
        end else if (m_st && !m_ad) begin
          if (m_h == {1'b0, DEV} || m_h == {1'b0, BC}) m_ad = 1;
          else m_st = 0;
        end else if (m_st && m_ad) begin
          m_ov = 1; m_oc = m_h;
          if (m_h == ETX) begin m_st = 0; m_ad = 0; end
        end
      end
      m_hv = rx_valid && !tx_busy;
      if (m_hv) m_h = rx_char;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (out_valid !== m_ov) begin
      failures++;
      $display("FAIL %s out_valid actual=%0b expected=%0b t=%0t", cur_req, out_valid, m_ov, $time);
    end
    checks++;
    if (rx_enable !== (m_st && m_ad)) begin
      failures++;
      $display("FAIL %s rx_enable actual=%0b expected=%0b t=%0t", cur_req, rx_enable, m_st && m_ad, $time);
    end
    if (m_ov) begin
      checks++;
      if (out_char !== m_oc) begin
        failures++;
        $display("FAIL %s out_char actual=%02h expected=%02h t=%0t", cur_req, out_char, m_oc, $time);
      end
    end
    if (out_valid) fwd_count++;
  end

  task automatic send(input logic [7:0] c);
    @(negedge clk);
    rx_char = c; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_count(input string req, input int exp);
    checks++;
    if (fwd_count != exp) begin
      failures++;
      $display("FAIL %s forwarded actual=%0d expected=%0d", req, fwd_count, exp);
    end
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);

    cur_req = "R4"; fwd_count = 0;     // own address, payload, end
    send(STX); send({1'b0, DEV}); send("A"); send("B"); send(ETX); idle(3);
    expect_count("R4_R8", 3);

    cur_req = "R10"; fwd_count = 0;    // stray characters on an idle line
    send("x"); send({1'b0, DEV}); send("y"); idle(3);
    expect_count("R10", 0);

    cur_req = "R5"; fwd_count = 0;     // broadcast, with gaps between characters
    send(STX); idle(2); send({1'b0, BC}); idle(3); send("C"); idle(1); send(ETX); idle(3);
    expect_count("R5", 2);

    cur_req = "R6"; fwd_count = 0;     // wrong address
    send(STX); send(8'h22); send("D"); send(ETX); idle(3);
    expect_count("R6", 0);

    cur_req = "R9"; fwd_count = 0;     // transmit starts in the middle of a message
    send(STX); send({1'b0, DEV}); send("E");
    @(negedge clk); tx_busy = 1'b1; @(negedge clk); tx_busy = 1'b0;
    send("F"); send(ETX); idle(3);
    expect_count("R9", 1);

    cur_req = "R2"; fwd_count = 0;     // characters offered while transmitting
    @(negedge clk); tx_busy = 1'b1;
    rx_char = STX; rx_valid = 1'b1; @(negedge clk);
    rx_char = {1'b0, DEV}; @(negedge clk);
    rx_char = "G"; @(negedge clk);
    rx_valid = 1'b0; tx_busy = 1'b0;
    send("H"); idle(3);
    expect_count("R2", 0);

    cur_req = "R3"; fwd_count = 0;     // double STX, then a restart in the middle of a message
    send(STX); send(STX); send({1'b0, DEV}); send("I");
    send(STX); send({1'b0, BC}); send("J"); send(ETX); idle(3);
    expect_count("R3", 3);

    cur_req = "R7"; fwd_count = 0;     // back-to-back payload
    send(STX); send({1'b0, DEV});
    for (int i = 0; i < 6; i++) send(8'h40 + 8'(i));
    send(ETX); idle(3);
    expect_count("R7", 7);

    cur_req = "R8"; fwd_count = 0;     // characters after the end are dropped
    send("K"); idle(2);
    expect_count("R8", 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule